// File: doc/BRIEF.md
# Main Memory Chip-Select Decoder

This block watches incoming bus accesses and raises a registered memory chip-select when an access lands in a part of main memory that is currently enabled. It knows three windows below 1 MB. The first is the base block from 0 to 512 KB. The second is the block from 512 KB to 640 KB. The third is the top 128 KB below 1 MB, which holds the boot firmware. Any address outside these windows is left alone, so another agent can claim it.

A single control register, reached through a small register port, sets which windows answer. One bit acts as a global switch. With that bit set, the base block always answers. Each of the other two windows has its own read permission bit and its own write permission bit. A read is claimed only when the window's read bit is set, and a write only when its write bit is set.

The chip-select is sampled from the access inputs on a clock edge and held for one cycle. It drops on the next edge unless another valid access is presented.

Top module: `mem_select_decoder`

## Requirements
- R1: After reset the control register reads 00h and `mem_cs` is 0.
- R2: While control bit 4 (global enable) is 0, `mem_cs` is never asserted, whatever bits 3:0 hold.
- R3: With bit 4 set, any valid read or write to 0x00000–0x7FFFF asserts `mem_cs`, regardless of bits 3:0.
- R4: With bit 4 set, a valid read to 0x80000–0x9FFFF asserts `mem_cs` only if bit 0 is set, and a valid write only if bit 1 is set. With both bits clear, no access to this window asserts `mem_cs`.
- R5: With bit 4 set, a valid read to 0xE0000–0xFFFFF asserts `mem_cs` only if bit 2 is set, and a valid write only if bit 3 is set.
- R6: Accesses to 0xA0000–0xDFFFF, or to 0x100000 and above, never assert `mem_cs`.
- R7: `mem_cs` is registered. It is high in the cycle after an edge where `acc_valid` was high with a claimed address, and low after any edge where `acc_valid` was low.
- R8: The control register is written and read at register offset 44h. Writes to other offsets leave it unchanged, and reads of other offsets return 00h.
- R9: Control bits 7:5 always read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 8 | Register port offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_valid | input | 1 | Access address valid strobe |
| mem_cs | output | 1 | Registered main-memory chip-select |

## Verification
The hardest case to reach is a window whose read and write permissions differ. In that case the same address must be claimed for one direction and refused for the other. The stimulus reaches it by rewriting the control register between accesses so that each permission bit is set alone. It then issues a read and a write to the same window, with addresses placed exactly on the window edges. The other cases are a write to an unused offset, which must not disturb the register, and an in-range address presented with the strobe low.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_LOW  = 2'd1,
    RGN_MID  = 2'd2,
    RGN_BIOS = 2'd3
  } region_e;

  // implemented control bit positions
  localparam int BIT_MID_RD  = 0;
  localparam int BIT_MID_WR  = 1;
  localparam int BIT_BIOS_RD = 2;
  localparam int BIT_BIOS_WR = 3;
  localparam int BIT_MASTER  = 4;
  localparam int CTRL_BITS   = 5;

endpackage

// File: rtl/mcs_rst_sync.sv
module mcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mcs_ctrl_reg.sv
module mcs_ctrl_reg
  import mcs_pkg::*;
#(
  parameter int              REG_AW      = 8,
  parameter int              REG_DW      = 8,
  parameter logic [REG_AW-1:0] CTRL_OFFSET = 8'h44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  output logic [CTRL_BITS-1:0] ctrl
);

  localparam int PAD_W = REG_DW - CTRL_BITS;

  logic                 sel;
  logic                 ctrl_en;
  logic [CTRL_BITS-1:0] ctrl_d;
  logic [CTRL_BITS-1:0] ctrl_q;

  always_comb begin
    sel     = (reg_addr == CTRL_OFFSET);
    ctrl_en = sel && reg_wr;
    ctrl_d  = reg_wdata[CTRL_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (sel) reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/mcs_region_decode.sv
module mcs_region_decode
  import mcs_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] LOW_END   = 32'h0007_FFFF,
  parameter logic [ADDR_W-1:0] MID_BASE  = 32'h0008_0000,
  parameter logic [ADDR_W-1:0] MID_END   = 32'h0009_FFFF,
  parameter logic [ADDR_W-1:0] BIOS_BASE = 32'h000E_0000,
  parameter logic [ADDR_W-1:0] BIOS_END  = 32'h000F_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  logic in_low;
  logic in_mid;
  logic in_bios;

  always_comb begin
    in_low  = (addr <= LOW_END);
    in_mid  = (addr >= MID_BASE)  && (addr <= MID_END);
    in_bios = (addr >= BIOS_BASE) && (addr <= BIOS_END);
    if (in_low)       region = RGN_LOW;
    else if (in_mid)  region = RGN_MID;
    else if (in_bios) region = RGN_BIOS;
    else              region = RGN_NONE;
  end

endmodule

// File: rtl/mcs_access_gate.sv
module mcs_access_gate
  import mcs_pkg::*;
(
  input  region_e              region,
  input  logic                 is_write,
  input  logic [CTRL_BITS-1:0] ctrl,
  output logic                 claim
);

  logic perm;

  always_comb begin
    unique case (region)
      RGN_LOW:  perm = 1'b1;
      RGN_MID:  perm = is_write ? ctrl[BIT_MID_WR]  : ctrl[BIT_MID_RD];
      RGN_BIOS: perm = is_write ? ctrl[BIT_BIOS_WR] : ctrl[BIT_BIOS_RD];
      default:  perm = 1'b0;
    endcase
    claim = ctrl[BIT_MASTER] && perm;
  end

endmodule

// File: rtl/mem_select_decoder.sv
module mem_select_decoder
  import mcs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_AW     = 8,
  parameter int REG_DW     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_valid,
  output logic              mem_cs
);

  logic                 rst_sync_n;
  logic [CTRL_BITS-1:0] ctrl_q;
  region_e              region;
  logic                 claim;
  logic                 cs_d;
  logic                 cs_q;

  mcs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  mcs_ctrl_reg #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ctrl     (ctrl_q)
  );

  mcs_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (acc_addr),
    .region(region)
  );

  mcs_access_gate u_gate (
    .region  (region),
    .is_write(acc_write),
    .ctrl    (ctrl_q),
    .claim   (claim)
  );

  always_comb begin
    cs_d = acc_valid && claim;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cs_q <= 1'b0;
    else             cs_q <= cs_d;
  end

  assign mem_cs = cs_q;

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker
  import mcs_pkg::*;
(
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic [31:0]          acc_addr,
  input logic                 acc_write,
  input logic                 acc_valid,
  input logic [CTRL_BITS-1:0] ctrl,
  input logic [7:0]           reg_rdata,
  input logic                 mem_cs
);

  p_strobe_needed_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_cs |-> $past(acc_valid));

  p_master_gate_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_cs |-> $past(ctrl[BIT_MASTER]));

  p_low_claim_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && ctrl[BIT_MASTER] && acc_addr < 32'h0008_0000) |=> mem_cs);

  p_mid_perm_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_cs && $past(acc_addr) >= 32'h0008_0000 && $past(acc_addr) <= 32'h0009_FFFF)
      |-> ($past(acc_write) ? $past(ctrl[BIT_MID_WR]) : $past(ctrl[BIT_MID_RD])));

  p_bios_perm_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_cs && $past(acc_addr) >= 32'h000E_0000 && $past(acc_addr) <= 32'h000F_FFFF)
      |-> ($past(acc_write) ? $past(ctrl[BIT_BIOS_WR]) : $past(ctrl[BIT_BIOS_RD])));

  p_hole_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_cs |-> ($past(acc_addr) < 32'h000A_0000 ||
                ($past(acc_addr) >= 32'h000E_0000 && $past(acc_addr) < 32'h0010_0000)));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rdata[7:5] == 3'b000);

endmodule

bind mem_select_decoder mcs_checker u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .acc_addr  (acc_addr),
  .acc_write (acc_write),
  .acc_valid (acc_valid),
  .ctrl      (ctrl_q),
  .reg_rdata (reg_rdata),
  .mem_cs    (mem_cs)
);

// File: tb/mem_select_decoder_test.sv
`timescale 1ns/1ps
module mem_select_decoder_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [31:0] acc_addr;
  logic        acc_write;
  logic        acc_valid;
  logic        mem_cs;

  int checks = 0;
  int errors = 0;

  mem_select_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_valid(acc_valid), .mem_cs(mem_cs)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, {24'h0, reg_rdata}, {24'h0, exp});
    reg_addr = 8'h00;
  endtask

  // one access, checked one edge later, then an idle cycle checked low
  task automatic access(input logic [31:0] a, input logic wr, input logic exp, input string req);
    @(negedge clk);
    acc_addr = a; acc_write = wr; acc_valid = 1'b1;
    @(negedge clk);
    check(req, {31'h0, mem_cs}, {31'h0, exp});
    acc_valid = 1'b0;
    @(negedge clk);
    check("R7 idle", {31'h0, mem_cs}, 32'h0);
  endtask

  task automatic t_reset;
    reg_read(8'h44, 8'h00, "R1 reset ctrl");
    check("R1 reset cs", {31'h0, mem_cs}, 32'h0);
  endtask

  task automatic t_master_off;
    reg_write(8'h44, 8'h0F);
    access(32'h0000_1000, 1'b0, 1'b0, "R2 low read master off");
    access(32'h0008_0000, 1'b0, 1'b0, "R2 mid read master off");
    access(32'h000F_0000, 1'b1, 1'b0, "R2 bios write master off");
  endtask

  task automatic t_register;
    reg_write(8'h44, 8'hFF);
    reg_read(8'h44, 8'h1F, "R9 reserved read zero");
    reg_write(8'h45, 8'h00);
    reg_read(8'h44, 8'h1F, "R8 other offset write ignored");
    reg_read(8'h45, 8'h00, "R8 other offset reads zero");
  endtask

  task automatic t_low;
    reg_write(8'h44, 8'h10);
    access(32'h0000_0000, 1'b0, 1'b1, "R3 low read");
    access(32'h0007_FFFF, 1'b1, 1'b1, "R3 low write top");
    access(32'h0008_0000, 1'b0, 1'b0, "R4 mid read no perm");
    access(32'h0009_FFFF, 1'b1, 1'b0, "R4 mid write no perm");
    access(32'h000E_0000, 1'b0, 1'b0, "R5 bios read no perm");
  endtask

  task automatic t_mid;
    reg_write(8'h44, 8'h11);
    access(32'h0008_0000, 1'b0, 1'b1, "R4 mid read en");
    access(32'h0008_0000, 1'b1, 1'b0, "R4 mid write off");
    reg_write(8'h44, 8'h12);
    access(32'h0009_FFFF, 1'b1, 1'b1, "R4 mid write en");
    access(32'h0009_FFFF, 1'b0, 1'b0, "R4 mid read off");
  endtask

  task automatic t_bios;
    reg_write(8'h44, 8'h14);
    access(32'h000E_0000, 1'b0, 1'b1, "R5 bios read en");
    access(32'h000E_0000, 1'b1, 1'b0, "R5 bios write off");
    reg_write(8'h44, 8'h18);
    access(32'h000F_FFFF, 1'b1, 1'b1, "R5 bios write en");
    access(32'h000F_FFFF, 1'b0, 1'b0, "R5 bios read off");
  endtask

  task automatic t_holes;
    reg_write(8'h44, 8'h1F);
    access(32'h000A_0000, 1'b0, 1'b0, "R6 hole base");
    access(32'h000D_FFFF, 1'b1, 1'b0, "R6 hole top");
    access(32'h0010_0000, 1'b0, 1'b0, "R6 above 1MB");
    access(32'hFFFF_FFFF, 1'b1, 1'b0, "R6 top of space");
  endtask

  task automatic t_timing;
    reg_write(8'h44, 8'h10);
    @(negedge clk);
    acc_addr = 32'h0000_2000; acc_write = 1'b0; acc_valid = 1'b0;
    @(negedge clk);
    check("R7 no strobe", {31'h0, mem_cs}, 32'h0);
    acc_valid = 1'b1;
    @(negedge clk);
    check("R7 back to back 1", {31'h0, mem_cs}, 32'h1);
    acc_addr = 32'h000A_0000;
    @(negedge clk);
    check("R7 back to back 2", {31'h0, mem_cs}, 32'h0);
    acc_addr = 32'h0000_3000;
    @(negedge clk);
    check("R7 back to back 3", {31'h0, mem_cs}, 32'h1);
    acc_valid = 1'b0;
    @(negedge clk);
    check("R7 strobe dropped", {31'h0, mem_cs}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_addr = 8'h00; reg_wr = 1'b0; reg_wdata = 8'h00;
    acc_addr = 32'h0; acc_write = 1'b0; acc_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_master_off();
    t_register();
    t_low();
    t_mid();
    t_bios();
    t_holes();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule